// File: doc/BRIEF.md
# Restoring Wide Divider with Divide Error

This block divides a double-width dividend, given as an upper and a lower half, by a single-width divisor. It returns a single-width quotient and remainder, in either unsigned or signed (two's complement) form. A request is presented with a one-cycle `start_i` pulse. The block answers with a one-cycle `done_o` pulse that carries either a result or a raised `err_o`.

The core is a restoring divider that works on magnitudes. It first doubles a copy of the divisor for as long as the copy does not exceed the running dividend, counting the doublings. It then walks back down one bit per cycle: each step halves the copy, shifts the quotient left and tries a subtraction. A step that borrows is undone, and a step that fits keeps its difference and sets the quotient's low bit. A small dividend therefore finishes after only a few steps. Sign handling wraps the core: the magnitudes go in and the signs are applied on the way out.

A zero divisor is rejected on the spot without starting the core. A quotient that cannot be represented in the result width also raises the error flag. In that case the quotient and remainder outputs keep the values of the last successful division.

Top module: `wide_divider`

## Requirements
- R1: Unsigned mode (`signed_i`=0): `quo_o` = floor(D / V) and `rem_o` = D mod V, where D = {`dvd_hi_i`,`dvd_lo_i`} and V = `dvs_i`.
- R2: A request with `dvs_i`=0 gives `done_o`=1 and `err_o`=1 on the first rising edge after it is accepted. `busy_o` stays 0 for that request.
- R3: Normalization doubles the divisor copy at most 2*W times. It stops at the first copy that exceeds the running dividend, so a full-range dividend with divisor 1 still completes.
- R4: Each reduction step shifts the quotient left by one and sets its new low bit exactly when the trial subtraction does not borrow. The remainder is whatever is left of the dividend after the last step.
- R5: The remainder magnitude is always less than the divisor magnitude.
- R6: In unsigned mode, a quotient of 2^W or more sets `err_o`=1 with `done_o`. On any error, `quo_o` and `rem_o` keep their previous values.
- R7: Signed mode (`signed_i`=1) divides the magnitudes and rounds the quotient toward zero. The quotient is negated when the signs of dividend and divisor differ, and the remainder takes the sign of the dividend.
- R8: In signed mode `err_o` is raised when a positive quotient exceeds 2^(W-1)-1 or a negative quotient is below -2^(W-1). Exactly -2^(W-1) is valid.
- R9: `done_o` is high for a single cycle per accepted request. `busy_o` is 1 from the cycle after a nonzero-divisor request is accepted until `done_o`. A `start_i` seen while `busy_o`=1 is ignored and produces no result.
- R10: A dividend smaller than the divisor completes with quotient 0 and the dividend as the remainder.
- R11: After reset `done_o`, `err_o` and `busy_o` are 0, and `quo_o` and `rem_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse; accepted when `busy_o` is 0 |
| signed_i | input | 1 | 1 selects two's complement operands |
| dvd_hi_i | input | W | Upper half of the dividend |
| dvd_lo_i | input | W | Lower half of the dividend |
| dvs_i | input | W | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Divide error, valid with `done_o` |
| quo_o | output | W | Quotient of the last successful division |
| rem_o | output | W | Remainder of the last successful division |

## Verification
A zero-divisor request has a fixed latency: its error is due at the first falling edge after the accepting rising edge, and the driver samples exactly there. Every other request has a data-dependent latency: one cycle per doubling, one per reduction step, plus two cycles, and never more than 4*W+3. For these, the expected result is queued when the request is issued. A monitor compares results in order on each falling edge where `done_o` is high, so timing variation never causes a mismatch. The driver also checks `busy_o` one cycle after acceptance, and it checks that a `start_i` pulse issued while the block is busy yields no `done_o` on the next cycle and no extra result.

// File: rtl/wdiv_pkg.sv
package wdiv_pkg;
    typedef enum logic [1:0] {
        CORE_IDLE = 2'd0,
        CORE_NORM = 2'd1,
        CORE_RED  = 2'd2,
        CORE_FIN  = 2'd3
    } core_st_e;
endpackage

// File: rtl/wdiv_prep.sv
module wdiv_prep #(
    parameter int W = 64
) (
    input  logic [2*W-1:0] dvd_i,
    input  logic [W-1:0]   dvs_i,
    input  logic           signed_i,
    output logic [2*W-1:0] mag_dvd_o,
    output logic [W-1:0]   mag_dvs_o,
    output logic           neg_quo_o,
    output logic           neg_rem_o
);
    localparam int DW = 2 * W;

    logic dvd_neg;
    logic dvs_neg;

    always_comb begin
        dvd_neg   = signed_i & dvd_i[DW-1];
        dvs_neg   = signed_i & dvs_i[W-1];
        mag_dvd_o = dvd_neg ? (~dvd_i + DW'(1)) : dvd_i;
        mag_dvs_o = dvs_neg ? (~dvs_i + W'(1)) : dvs_i;
        neg_quo_o = dvd_neg ^ dvs_neg;
        neg_rem_o = dvd_neg;
    end
endmodule

// File: rtl/wdiv_core.sv
module wdiv_core
    import wdiv_pkg::*;
#(
    parameter int W = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_i,
    input  logic [2*W-1:0] dvd_i,
    input  logic [W-1:0]   dvs_i,
    output logic           busy_o,
    output logic           fin_o,
    output logic [2*W-1:0] quo_o,
    output logic [W-1:0]   rem_o
);
    localparam int DW = 2 * W;
    localparam int NW = $clog2(DW + 1);

    typedef struct packed {
        core_st_e      st;
        logic [NW-1:0] cnt;
        logic [DW:0]   den;
        logic [DW-1:0] acc;
        logic [DW-1:0] quo;
    } core_t;

    core_t cur_q;
    core_t nxt_d;
    logic [DW:0] half_den;
    logic [DW:0] acc_ext;

    always_comb begin
        nxt_d    = cur_q;
        half_den = cur_q.den >> 1;
        acc_ext  = {1'b0, cur_q.acc};
        unique case (cur_q.st)
            CORE_IDLE: begin
                if (go_i) begin
                    nxt_d.st  = CORE_NORM;
                    nxt_d.cnt = '0;
                    nxt_d.den = {{(DW + 1 - W){1'b0}}, dvs_i};
                    nxt_d.acc = dvd_i;
                    nxt_d.quo = '0;
                end
            end
            CORE_NORM: begin
                if ((cur_q.den <= acc_ext) && (cur_q.cnt < NW'(DW))) begin
                    nxt_d.den = cur_q.den << 1;
                    nxt_d.cnt = cur_q.cnt + NW'(1);
                end else begin
                    nxt_d.st = (cur_q.cnt == '0) ? CORE_FIN : CORE_RED;
                end
            end
            CORE_RED: begin
                nxt_d.den = half_den;
                nxt_d.cnt = cur_q.cnt - NW'(1);
                if (half_den <= acc_ext) begin
                    nxt_d.acc = cur_q.acc - half_den[DW-1:0];
                    nxt_d.quo = {cur_q.quo[DW-2:0], 1'b1};
                end else begin
                    nxt_d.quo = {cur_q.quo[DW-2:0], 1'b0};
                end
                if (cur_q.cnt == NW'(1)) begin
                    nxt_d.st = CORE_FIN;
                end
            end
            default: begin
                nxt_d.st = CORE_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: CORE_IDLE, cnt: '0, den: '0, acc: '0, quo: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy_o = (cur_q.st != CORE_IDLE);
    assign fin_o  = (cur_q.st == CORE_FIN);
    assign quo_o  = cur_q.quo;
    assign rem_o  = cur_q.acc[W-1:0];

    // R3: the doubling count never passes its limit
    p_norm_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == CORE_NORM) |-> (cur_q.cnt <= NW'(DW)));

    // R4: a reduction step always has a pending count
    p_red_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == CORE_RED) |-> (cur_q.cnt != '0));

    // R4: quotient bits move up by one per reduction step
    p_quo_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == CORE_RED) |=> (cur_q.quo[DW-1:1] == $past(cur_q.quo[DW-2:0])));

    // R5: the leftover dividend is below the restored divisor
    p_rem_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == CORE_FIN) |-> ({1'b0, cur_q.acc} < cur_q.den));
endmodule

// File: rtl/wdiv_post.sv
module wdiv_post #(
    parameter int W = 64
) (
    input  logic [2*W-1:0] quo_mag_i,
    input  logic [W-1:0]   rem_mag_i,
    input  logic           neg_quo_i,
    input  logic           neg_rem_i,
    input  logic           signed_i,
    output logic [W-1:0]   quo_o,
    output logic [W-1:0]   rem_o,
    output logic           ovf_o
);
    localparam int DW = 2 * W;
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W - 1){1'b0}}};

    logic          hi_set;
    logic [W-1:0]  lo_mag;

    always_comb begin
        hi_set = |quo_mag_i[DW-1:W];
        lo_mag = quo_mag_i[W-1:0];
        if (!signed_i) begin
            ovf_o = hi_set;
        end else if (neg_quo_i) begin
            ovf_o = hi_set | (lo_mag > NEG_LIMIT);
        end else begin
            ovf_o = hi_set | lo_mag[W-1];
        end
        quo_o = neg_quo_i ? (~lo_mag + W'(1)) : lo_mag;
        rem_o = neg_rem_i ? (~rem_mag_i + W'(1)) : rem_mag_i;
    end
endmodule

// File: rtl/wide_divider.sv
module wide_divider #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] dvd_hi_i,
    input  logic [W-1:0] dvd_lo_i,
    input  logic [W-1:0] dvs_i,
    output logic         busy_o,
    output logic         done_o,
    output logic         err_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int DW = 2 * W;

    typedef struct packed {
        logic         done;
        logic         err;
        logic [W-1:0] quo;
        logic [W-1:0] rem;
        logic         sgn;
        logic         neg_quo;
        logic         neg_rem;
    } top_t;

    top_t top_q;
    top_t top_d;

    logic [DW-1:0] mag_dvd;
    logic [W-1:0]  mag_dvs;
    logic          neg_quo;
    logic          neg_rem;
    logic          accept;
    logic          core_go;
    logic          core_busy;
    logic          core_fin;
    logic [DW-1:0] core_quo;
    logic [W-1:0]  core_rem;
    logic [W-1:0]  fix_quo;
    logic [W-1:0]  fix_rem;
    logic          fix_ovf;

    wdiv_prep #(.W(W)) prep_i (
        .dvd_i     ({dvd_hi_i, dvd_lo_i}),
        .dvs_i     (dvs_i),
        .signed_i  (signed_i),
        .mag_dvd_o (mag_dvd),
        .mag_dvs_o (mag_dvs),
        .neg_quo_o (neg_quo),
        .neg_rem_o (neg_rem)
    );

    wdiv_core #(.W(W)) core_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (core_go),
        .dvd_i  (mag_dvd),
        .dvs_i  (mag_dvs),
        .busy_o (core_busy),
        .fin_o  (core_fin),
        .quo_o  (core_quo),
        .rem_o  (core_rem)
    );

    wdiv_post #(.W(W)) post_i (
        .quo_mag_i (core_quo),
        .rem_mag_i (core_rem),
        .neg_quo_i (top_q.neg_quo),
        .neg_rem_i (top_q.neg_rem),
        .signed_i  (top_q.sgn),
        .quo_o     (fix_quo),
        .rem_o     (fix_rem),
        .ovf_o     (fix_ovf)
    );

    assign accept  = start_i & ~core_busy;
    assign core_go = accept & (dvs_i != '0);

    always_comb begin
        top_d      = top_q;
        top_d.done = 1'b0;
        top_d.err  = 1'b0;
        if (accept) begin
            top_d.sgn     = signed_i;
            top_d.neg_quo = neg_quo;
            top_d.neg_rem = neg_rem;
            if (dvs_i == '0) begin
                top_d.done = 1'b1;
                top_d.err  = 1'b1;
            end
        end
        if (core_fin) begin
            top_d.done = 1'b1;
            top_d.err  = fix_ovf;
            if (!fix_ovf) begin
                top_d.quo = fix_quo;
                top_d.rem = fix_rem;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign busy_o = core_busy;
    assign done_o = top_q.done;
    assign err_o  = top_q.err;
    assign quo_o  = top_q.quo;
    assign rem_o  = top_q.rem;

    // R2: zero divisor answers with an error on the next edge
    p_zero_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (dvs_i == '0)) |=> (done_o && err_o));

    // R6: an error leaves the result outputs untouched
    p_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> ($stable(quo_o) && $stable(rem_o)));

    // R9: completion is a single-cycle pulse when no new request follows
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    // R9: the error flag only appears together with completion
    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);
endmodule

// File: tb/wide_divider_tb_top.sv
module wide_divider_tb_top;
    localparam int W  = 64;
    localparam int DW = 2 * W;

    typedef struct {
        logic         err;
        logic [W-1:0] quo;
        logic [W-1:0] rem;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] dvd_hi_i = '0;
    logic [W-1:0] dvd_lo_i = '0;
    logic [W-1:0] dvs_i = '0;
    logic         busy_o;
    logic         done_o;
    logic         err_o;
    logic [W-1:0] quo_o;
    logic [W-1:0] rem_o;

    int   total = 0;
    int   bad = 0;
    exp_t sb[$];
    logic [W-1:0] last_quo = '0;
    logic [W-1:0] last_rem = '0;

    always #10 clk = ~clk;

    wide_divider #(.W(W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .signed_i (signed_i),
        .dvd_hi_i (dvd_hi_i),
        .dvd_lo_i (dvd_lo_i),
        .dvs_i    (dvs_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .err_o    (err_o),
        .quo_o    (quo_o),
        .rem_o    (rem_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input bit sgn, input logic [DW-1:0] dvd,
                                   input logic [W-1:0] dvs, input string tag);
        exp_t e;
        logic [DW-1:0] q;
        logic [DW-1:0] r;
        e.tag = tag;
        e.err = 1'b0;
        if (dvs == '0) begin
            e.err = 1'b1;
        end else if (!sgn) begin
            q = dvd / {{W{1'b0}}, dvs};
            r = dvd % {{W{1'b0}}, dvs};
            e.err = (q[DW-1:W] != '0);
        end else begin
            q = $signed(dvd) / $signed({{W{dvs[W-1]}}, dvs});
            r = $signed(dvd) % $signed({{W{dvs[W-1]}}, dvs});
            e.err = (q != {{W{q[W-1]}}, q[W-1:0]});
        end
        if (e.err) begin
            e.quo = last_quo;
            e.rem = last_rem;
        end else begin
            e.quo = q[W-1:0];
            e.rem = r[W-1:0];
            last_quo = e.quo;
            last_rem = e.rem;
        end
        return e;
    endfunction

    task automatic run_div(input bit sgn, input logic [W-1:0] hi, input logic [W-1:0] lo,
                           input logic [W-1:0] dvs, input string tag, input bit poke_busy);
        while (busy_o) @(negedge clk);
        signed_i = sgn;
        dvd_hi_i = hi;
        dvd_lo_i = lo;
        dvs_i    = dvs;
        start_i  = 1'b1;
        sb.push_back(model(sgn, {hi, lo}, dvs, tag));
        @(negedge clk);
        start_i = 1'b0;
        if (dvs == '0) begin
            check(done_o && err_o, "R2", "zero divisor done&err", W'({done_o, err_o}), W'(2'b11));
            check(!busy_o, "R2", "busy on zero divisor", W'(busy_o), '0);
        end else begin
            check(busy_o, "R9", "busy after accept", W'(busy_o), W'(1));
            if (poke_busy) begin
                dvs_i   = '0;
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                check(!done_o, "R9", "start while busy gave done", W'(done_o), '0);
            end
        end
        while (sb.size() != 0) @(negedge clk);
    endtask

    // monitor: compare each completion with the head of the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", W'(done_o), '0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(err_o == e.err, e.tag, "err", W'(err_o), W'(e.err));
                    check(quo_o == e.quo, e.tag, "quotient", quo_o, e.quo);
                    check(rem_o == e.rem, e.tag, "remainder", rem_o, e.rem);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam logic [W-1:0] ONES = '1;
    localparam logic [W-1:0] MSB  = {1'b1, {(W - 1){1'b0}}};

    initial begin
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] c;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!done_o && !err_o && !busy_o, "R11", "flags after reset",
              W'({done_o, err_o, busy_o}), '0);
        check(quo_o == '0 && rem_o == '0, "R11", "results after reset", quo_o | rem_o, '0);
        rst_n = 1'b1;
        @(negedge clk);

        run_div(1'b0, '0, W'(100), W'(7), "R1", 1'b0);
        run_div(1'b0, W'(3), W'(64'h0123_4567_89ab_cdef), W'(16), "R1", 1'b0);
        run_div(1'b0, ONES - 1, ONES, ONES, "R1", 1'b0);
        run_div(1'b0, '0, W'(5), W'(9), "R10", 1'b0);
        run_div(1'b1, ONES, ONES - W'(4), W'(100), "R10", 1'b0);
        run_div(1'b0, W'(5), W'(77), W'(5), "R6", 1'b0);
        run_div(1'b0, ONES, ONES, ONES, "R6", 1'b0);
        run_div(1'b0, ONES, ONES, W'(1), "R3", 1'b0);
        run_div(1'b0, '0, ONES, W'(1), "R3", 1'b0);
        run_div(1'b0, '0, W'(77), '0, "R2", 1'b0);
        run_div(1'b1, ONES, W'(-100), W'(7), "R7", 1'b0);
        run_div(1'b1, '0, W'(100), W'(-7), "R7", 1'b0);
        run_div(1'b1, ONES, W'(-100), W'(-7), "R7", 1'b0);
        run_div(1'b1, '0, MSB, W'(1), "R8", 1'b0);
        run_div(1'b1, ONES, MSB, W'(1), "R8", 1'b0);
        run_div(1'b1, '0, MSB, ONES, "R8", 1'b0);
        run_div(1'b1, ONES, MSB, ONES, "R8", 1'b0);
        run_div(1'b1, ONES, '0, W'(2), "R8", 1'b0);
        run_div(1'b1, '0, W'(1234567), '0, "R2", 1'b0);
        run_div(1'b0, W'(2), W'(999), W'(1000), "R9", 1'b1);
        a = W'(64'h9e37_79b9_7f4a_7c15);
        b = W'(64'hbf58_476d_1ce4_e5b9);
        for (int i = 0; i < 16; i++) begin
            a = a * W'(64'h5851_f42d_4c95_7f2d) + W'(64'h1405_7b7e_f767_814f);
            b = b ^ (b << 13);
            b = b ^ (b >> 7);
            b = b ^ (b << 17);
            c = (b >> (i * 3)) | W'(1);
            run_div(1'b0, a % c, b, c, "R4", 1'b0);
            run_div(1'b1, {1'b0, a[W-2:0]} >> (i * 4), b, c ^ MSB, "R5", 1'b0);
        end
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R9", "pending results", W'(sb.size()), '0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule